// File: doc/BRIEF.md
# Display Underflow Recovery Watchdog

This block watches the per-window FIFO underflow events of a display controller with three overlay windows. Underflows seen during a frame are collected into a sticky pending mask. At each vertical blank the block closes the frame. Each window with a pending underflow advances its own count of consecutive bad frames. A window that was clean has its count cleared.

An overlay that keeps underflowing frame after frame is taken to have corrupted internal state, and only a controller reset clears that state. Once any window's count goes above the threshold, the block runs a fixed recovery sequence. It first drops the controller enable. It then raises the peripheral reset and holds it for a set number of clock cycles. Next it releases the reset, and one cycle later it restores the enable. The vertical-blank interrupt enable output is high only while underflows are being tracked, so the blanking interrupt costs nothing during healthy operation.

Top module: `uf_recovery_watchdog`

## Requirements
- R1: After reset, `vbl_irq_en` is 0, `ctrl_enable` is 1, `periph_reset` is 0 and `recovering` is 0.
- R2: Outside recovery, a cycle with any `uf_evt` bit high and `vblank` low sets `vbl_irq_en` to 1 from the next cycle on.
- R3: On a `vblank` cycle outside recovery, `vbl_irq_en` becomes 1 if the pending mask or the current `uf_evt` is nonzero, and 0 otherwise.
- R4: Each window keeps its own count of consecutive frames with an underflow. The frame that brings a count above `THRESH` (the fifth frame with the default of 4) starts recovery. `recovering` is 1 in the cycle after that `vblank` cycle.
- R5: A frame closed by `vblank` with no underflow on a window sets that window's count to 0. A window that underflows again afterwards starts over from one.
- R6: Windows are counted separately. Underflows that alternate between two windows never start recovery. A bit position `w` of `uf_evt` belongs to window `w` alone.
- R7: An underflow pulse in the same cycle as `vblank` counts toward the frame being closed.
- R8: Recovery runs in this order. First, one cycle with `ctrl_enable`=0 and `periph_reset`=0. Second, `HOLD_CYCLES` cycles with `periph_reset`=1. Third, one cycle with `periph_reset`=0 and `ctrl_enable` still 0. After that, `ctrl_enable` returns to 1 and `recovering` to 0.
- R9: Underflow and `vblank` pulses during recovery are ignored. They neither lengthen nor restart the sequence.
- R10: When recovery ends, all counts and the pending mask are cleared and `vbl_irq_en` is 0. After that, a full `THRESH`+1 consecutive bad frames is needed to start recovery again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uf_evt | input | NWIN | Per-window underflow pulses, bit w for window w |
| vblank | input | 1 | Vertical-blank pulse closing a frame |
| vbl_irq_en | output | 1 | Vertical-blank interrupt enable request |
| ctrl_enable | output | 1 | Display controller enable request |
| periph_reset | output | 1 | Peripheral reset to the controller, active high |
| recovering | output | 1 | High while the recovery sequence runs |

## Verification
The bench builds the block with `HOLD_CYCLES` set to 6 and keeps `THRESH` at 4 with three windows. With a short hold, the whole recovery sequence can be checked cycle by cycle. The fifth-frame trigger, the reset of counts on a clean frame, and the clearing of state after recovery are all reached within a few dozen cycles. The short hold also leaves room to inject underflows and blanking pulses in the middle of the reset hold.

// File: rtl/uf_recovery_watchdog.sv
module uf_recovery_watchdog #(
  parameter int NWIN        = 3,
  parameter int THRESH      = 4,
  parameter int HOLD_CYCLES = 1000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NWIN-1:0] uf_evt,
  input  logic            vblank,
  output logic            vbl_irq_en,
  output logic            ctrl_enable,
  output logic            periph_reset,
  output logic            recovering
);
  localparam int CW = $clog2(THRESH + 2);
  localparam int TW = $clog2(HOLD_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_OFF, S_HOLD, S_REL} st_t;

  st_t             st;
  logic [TW-1:0]   tmr;
  logic [NWIN-1:0] pend, acc, over;
  logic [CW-1:0]   cnt [NWIN];
  logic            vbl_q;
  logic            idle, trigger;

  assign idle    = (st == S_IDLE);
  assign acc     = pend | uf_evt;
  assign trigger = idle && vblank && (|over);

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign over[w] = acc[w] && (cnt[w] >= CW'(THRESH));
    always_ff @(posedge clk) begin
      if (!rst_n || st == S_REL)
        cnt[w] <= '0;
      else if (idle && vblank)
        cnt[w] <= !acc[w] ? '0 : (&cnt[w]) ? cnt[w] : cnt[w] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !idle || vblank) pend <= '0;
    else                           pend <= acc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !idle) vbl_q <= 1'b0;
    else if (vblank)     vbl_q <= |acc;
    else if (|uf_evt)    vbl_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      tmr <= '0;
    end else begin
      case (st)
        S_IDLE: if (trigger) st <= S_OFF;
        S_OFF: begin
          st  <= S_HOLD;
          tmr <= '0;
        end
        S_HOLD:
          if (tmr == TW'(HOLD_CYCLES - 1)) st <= S_REL;
          else tmr <= tmr + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign vbl_irq_en   = vbl_q;
  assign ctrl_enable  = idle;
  assign periph_reset = (st == S_HOLD);
  assign recovering   = !idle;

  p_uf_arms_vbl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && (|uf_evt) && !vblank) |=> vbl_irq_en);

  p_vbl_off_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && vblank && pend == '0 && uf_evt == '0) |=> !vbl_irq_en);

  p_disable_before_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(periph_reset) |-> $past(!ctrl_enable));

  p_release_before_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_enable) |-> $past(!periph_reset));

  p_recovery_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (recovering && st != S_REL) |=> recovering);

  p_cleared_on_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(recovering) |-> (pend == '0 && !vbl_irq_en));
endmodule

// File: tb/uf_recovery_watchdog_tb.sv
module uf_recovery_watchdog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 6;

  logic clk = 1'b0, rst_n = 1'b0, vblank = 1'b0;
  logic [2:0] uf_evt = '0;
  logic vbl_irq_en, ctrl_enable, periph_reset, recovering;
  int checks = 0, fails = 0;

  uf_recovery_watchdog #(.NWIN(3), .THRESH(4), .HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .uf_evt(uf_evt), .vblank(vblank),
    .vbl_irq_en(vbl_irq_en), .ctrl_enable(ctrl_enable),
    .periph_reset(periph_reset), .recovering(recovering));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {uf_evt, vblank, expected vbl_irq_en}
  localparam logic [4:0] VEC [11] = '{
    5'b000_0_0, 5'b001_0_1, 5'b000_0_1, 5'b000_1_1, 5'b000_0_1, 5'b000_1_0,
    5'b100_1_1, 5'b000_1_0, 5'b010_0_1, 5'b000_1_1, 5'b000_1_0};

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [2:0] u, input logic v);
    @(negedge clk);
    uf_evt = u;
    vblank = v;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; uf_evt = '0; vblank = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic frame(input logic [2:0] m, input logic same);
    if (same) cyc(m, 1'b1);
    else begin
      cyc(m, 1'b0);
      cyc(3'b000, 1'b0);
      cyc(3'b000, 1'b1);
    end
  endtask

  task automatic finish_recovery();
    for (int i = 0; i < HOLD + 4 && recovering; i++) cyc(3'b000, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk("R1 vbl_irq_en", vbl_irq_en, 1'b0);
    chk("R1 ctrl_enable", ctrl_enable, 1'b1);
    chk("R1 periph_reset", periph_reset, 1'b0);
    chk("R1 recovering", recovering, 1'b0);

    for (int i = 0; i < 11; i++) begin
      cyc(VEC[i][4:2], VEC[i][1]);
      chk("R2/R3 vector vbl_irq_en", vbl_irq_en, VEC[i][0]);
      chk("R2/R3 vector recovering", recovering, 1'b0);
    end

    // R4: fifth consecutive frame triggers; R8 sequence; R9 ignore
    do_reset();
    for (int f = 0; f < 4; f++) begin
      frame(3'b001, 1'b0);
      chk("R4 no trigger before fifth", recovering, 1'b0);
    end
    frame(3'b001, 1'b0);
    chk("R4 fifth frame triggers", recovering, 1'b1);
    chk("R8 off phase enable", ctrl_enable, 1'b0);
    chk("R8 off phase reset", periph_reset, 1'b0);
    for (int i = 0; i < HOLD; i++) begin
      cyc(3'b111, i[0]);
      chk("R8 R9 hold reset high", periph_reset, 1'b1);
      chk("R8 hold enable low", ctrl_enable, 1'b0);
    end
    cyc(3'b111, 1'b1);
    chk("R8 release reset low", periph_reset, 1'b0);
    chk("R8 release enable low", ctrl_enable, 1'b0);
    chk("R8 release recovering", recovering, 1'b1);
    cyc(3'b000, 1'b0);
    chk("R8 R9 enable restored", ctrl_enable, 1'b1);
    chk("R9 recovery ended on time", recovering, 1'b0);
    chk("R10 vbl_irq_en cleared", vbl_irq_en, 1'b0);
    for (int f = 0; f < 4; f++) begin
      frame(3'b001, 1'b0);
      chk("R10 counts cleared", recovering, 1'b0);
    end
    frame(3'b001, 1'b0);
    chk("R10 full run retriggers", recovering, 1'b1);
    finish_recovery();

    // R5: clean frame resets the count
    do_reset();
    for (int f = 0; f < 4; f++) frame(3'b010, 1'b0);
    frame(3'b000, 1'b0);
    chk("R5 clean frame", recovering, 1'b0);
    for (int f = 0; f < 4; f++) begin
      frame(3'b010, 1'b0);
      chk("R5 count restarted", recovering, 1'b0);
    end

    // R6: windows independent
    do_reset();
    for (int f = 0; f < 10; f++) begin
      frame(f[0] ? 3'b010 : 3'b001, 1'b0);
      chk("R6 alternating windows", recovering, 1'b0);
    end
    for (int f = 0; f < 4; f++) frame(3'b100, 1'b0);
    chk("R6 window 2 fourth", recovering, 1'b0);
    frame(3'b100, 1'b0);
    chk("R6 window 2 fifth", recovering, 1'b1);
    finish_recovery();

    // R7: same-cycle underflow belongs to closing frame
    do_reset();
    for (int f = 0; f < 4; f++) begin
      frame(3'b010, 1'b1);
      chk("R7 same-cycle vbl_irq_en", vbl_irq_en, 1'b1);
    end
    chk("R7 not yet", recovering, 1'b0);
    frame(3'b010, 1'b1);
    chk("R7 same-cycle fifth triggers", recovering, 1'b1);
    finish_recovery();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule